// File: doc/BRIEF.md
# Packed SIMD Integer Lane

This block is the integer arithmetic lane of a small vector coprocessor. Each accepted request carries two 64-bit operand words, an operation code and a selected element width (SEW) of 8, 16, 32 or 64 bits. The word is treated as 8, 4, 2 or 1 packed elements, so 64 bits of operand data are processed on every accepted cycle at any width. Elementwise operations return one packed 64-bit result word per request.

The same datapath also reduces a vector to one scalar. A vector arrives one 64-bit word per request. The elements inside each word are folded in a small tree. The word result is then combined into an accumulator, which the first word seeds from element 0 of the second operand. A vector-length input gives the number of active elements. Slots past the end of the vector are replaced by the identity value of the operation. Only the final word produces an output, and that output is flagged as a finished reduction.

Requests enter through a valid/ready handshake. The result register has one cycle of latency and holds its value while the consumer stalls. The block has no masking, no saturation and no rounding.

Top module: `simd_int_lane`

## Requirements
- R1: Add (op 0) and subtract (op 1) work per element modulo 2^SEW, and no carry or borrow crosses an element boundary. The SEW code is 0=8, 1=16, 2=32, 3=64 bits, and element k sits at bits [k*SEW +: SEW].
- R2: AND (op 2), OR (op 3) and XOR (op 4) are bitwise across the whole word.
- R3: Shift left (op 5), logical right (op 6) and arithmetic right (op 7) shift each element of `in_a` by the low log2(SEW) bits of the matching element of `in_b`. The arithmetic shift fills with the element's sign bit.
- R4: Signed min (op 8), unsigned min (op 9), signed max (op 10) and unsigned max (op 11) pick per element between `in_a` and `in_b`.
- R5: Equal (op 12), signed less-than (op 13) and unsigned less-than (op 14) put the value 1 or 0 into each result element.
- R6: With `in_red`=1 and op one of 0, 2, 3, 4, 8, 9, 10, 11, the result is the op folded over the seed and every active element. The seed is the low SEW bits of `in_b` on the word marked `in_first`, and `in_b` is ignored on later words. The result appears in the low SEW bits of `out_data` with the upper bits zero and `out_done`=1.
- R7: `in_vl` (at least 1, held steady during a reduction) gives the active element count. A reduction takes ceil(vl/(64/SEW)) words. Element slots with index at or beyond vl do not affect the result.
- R8: A request accepted at a clock edge has its result at `out_valid` right after that edge. Elementwise results carry `out_done`=0.
- R9: While `out_valid`=1 and `out_ready`=0, `out_data` and `out_done` hold and `in_ready` is 0.
- R10: A synchronous active-low reset clears `out_valid` and `out_done` and drops any reduction in progress.
- R11: A reduction word that is not the last word produces no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_op | input | 4 | Operation code |
| in_sew | input | 2 | Element width code |
| in_red | input | 1 | Request is a reduction word |
| in_first | input | 1 | First word of a reduction |
| in_vl | input | VL_W | Active element count of the reduction |
| in_a | input | 64 | First operand word / reduction data word |
| in_b | input | 64 | Second operand word / reduction seed |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 64 | Result word or reduction scalar |
| out_done | output | 1 | Result is a finished reduction |

## Verification
Assertions check the timing on every cycle: the one-cycle path from an accepted request to a valid result, the result holding while the consumer stalls, no output for middle reduction words, a flagged output after a final word, and the element counter staying below the vector length. The values themselves can only be shown by the bench scenarios. These cover the wrap-around per element, shift amounts larger than the element, signed versus unsigned ordering, and reductions whose last word carries stale data in unused slots, compared against a behavioural model at all four widths.

// File: rtl/simd_lane_pkg.sv
// Package: shared operation and element-width encodings for the packed lane.
// Assumes a fixed 64-bit word; element widths are 8, 16, 32 and 64 bits.
package simd_lane_pkg;
    localparam int WORD_W = 64;
    localparam int NUM_SEW = 4;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_AND  = 4'd2,
        OP_OR   = 4'd3,
        OP_XOR  = 4'd4,
        OP_SLL  = 4'd5,
        OP_SRL  = 4'd6,
        OP_SRA  = 4'd7,
        OP_MIN  = 4'd8,
        OP_MINU = 4'd9,
        OP_MAX  = 4'd10,
        OP_MAXU = 4'd11,
        OP_SEQ  = 4'd12,
        OP_SLT  = 4'd13,
        OP_SLTU = 4'd14,
        OP_NONE = 4'd15
    } lane_op_e;

    typedef enum logic [1:0] {
        SEW_8  = 2'd0,
        SEW_16 = 2'd1,
        SEW_32 = 2'd2,
        SEW_64 = 2'd3
    } sew_e;
endpackage

// File: rtl/simd_lane_op.sv
// Module: one element ALU of width EW.
// Computes add/sub/logic/shift/min/max/compare on a single element.
// Assumes the shift amount is the low log2(EW) bits of b; results wrap at EW bits.
module simd_lane_op
    import simd_lane_pkg::*;
#(
    parameter int EW = 8
) (
    input  lane_op_e        op,
    input  logic [EW-1:0]   a,
    input  logic [EW-1:0]   b,
    output logic [EW-1:0]   y
);
    localparam int SH_W = $clog2(EW);

    logic [SH_W-1:0] sh;
    logic            lt_s;
    logic            lt_u;

    assign sh   = b[SH_W-1:0];
    assign lt_s = $signed(a) < $signed(b);
    assign lt_u = a < b;

    // Select the element result for the requested operation.
    always_comb begin : p_elem
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_SLL:  y = a << sh;
            OP_SRL:  y = a >> sh;
            OP_SRA:  y = EW'($signed(a) >>> sh);
            OP_MIN:  y = lt_s ? a : b;
            OP_MINU: y = lt_u ? a : b;
            OP_MAX:  y = lt_s ? b : a;
            OP_MAXU: y = lt_u ? b : a;
            OP_SEQ:  y = {{(EW-1){1'b0}}, a == b};
            OP_SLT:  y = {{(EW-1){1'b0}}, lt_s};
            OP_SLTU: y = {{(EW-1){1'b0}}, lt_u};
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/simd_pack_op.sv
// Module: packed 64-bit ALU.
// Builds one row of element ALUs for each supported width and picks the row
// matching the selected element width. No carry crosses an element boundary
// because each element has its own ALU.
module simd_pack_op
    import simd_lane_pkg::*;
(
    input  lane_op_e            op,
    input  sew_e                sew,
    input  logic [WORD_W-1:0]   a,
    input  logic [WORD_W-1:0]   b,
    output logic [WORD_W-1:0]   y
);
    logic [WORD_W-1:0] row_res [NUM_SEW];

    for (genvar gw = 0; gw < NUM_SEW; gw++) begin : g_row
        localparam int EW    = 8 << gw;
        localparam int LANES = WORD_W / EW;
        logic [WORD_W-1:0] row;
        for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
            simd_lane_op #(.EW(EW)) u_lane (
                .op (op),
                .a  (a[gl*EW +: EW]),
                .b  (b[gl*EW +: EW]),
                .y  (row[gl*EW +: EW])
            );
        end
        assign row_res[gw] = row;
    end

    // Route the row for the active element width to the output.
    always_comb begin : p_pick
        y = row_res[sew];
    end
endmodule

// File: rtl/simd_word_reduce.sv
// Module: in-word reduction.
// Replaces element slots at or beyond `active` with the op's identity, then
// folds the word in halves (32, 16, 8 bits apart) down to one element in the
// low SEW bits. Upper bits of `red` are don't-care. Assumes op is a reducible
// operation (add, and, or, xor, min/max signed or unsigned).
module simd_word_reduce
    import simd_lane_pkg::*;
(
    input  lane_op_e            op,
    input  sew_e                sew,
    input  logic [WORD_W-1:0]   word,
    input  logic [3:0]          active,
    output logic [WORD_W-1:0]   red
);
    logic [WORD_W-1:0] sign_bits;
    logic [WORD_W-1:0] ident;
    logic [WORD_W-1:0] filled;

    // Form the identity pattern of the op, replicated per element.
    always_comb begin : p_ident
        case (sew)
            SEW_8:   sign_bits = 64'h8080_8080_8080_8080;
            SEW_16:  sign_bits = 64'h8000_8000_8000_8000;
            SEW_32:  sign_bits = 64'h8000_0000_8000_0000;
            default: sign_bits = 64'h8000_0000_0000_0000;
        endcase
        case (op)
            OP_AND, OP_MINU: ident = '1;
            OP_MIN:          ident = ~sign_bits;
            OP_MAX:          ident = sign_bits;
            default:         ident = '0;
        endcase
    end

    // Keep bytes of active elements, substitute identity for the rest.
    always_comb begin : p_fill
        for (int i = 0; i < 8; i++) begin
            filled[i*8 +: 8] = ((4'(i) >> sew) < active) ? word[i*8 +: 8] : ident[i*8 +: 8];
        end
    end

    for (genvar gl = 0; gl < 3; gl++) begin : g_fold
        localparam int HALF = 32 >> gl;
        logic [WORD_W-1:0] v_in;
        logic [WORD_W-1:0] v_out;
        logic [WORD_W-1:0] folded;
        if (gl == 0) begin : g_src0
            assign v_in = filled;
        end else begin : g_srcn
            assign v_in = g_fold[gl-1].v_out;
        end
        simd_pack_op u_fold (
            .op  (op),
            .sew (sew),
            .a   (v_in),
            .b   (v_in >> HALF),
            .y   (folded)
        );
        assign v_out = (int'(sew) <= 2 - gl) ? folded : v_in;
    end

    assign red = g_fold[2].v_out;
endmodule

// File: rtl/simd_int_lane.sv
// Module: packed SIMD integer lane (top).
// Accepts one 64-bit request per cycle through valid/ready. Elementwise ops
// give a packed result word. Reduction words are folded in-word and combined
// into an accumulator; only the final word (found from in_vl and the elements
// consumed so far) yields an output, flagged by out_done. The output register
// adds one cycle of latency and holds under backpressure.
// Assumes in_vl >= 1 and steady for the length of a reduction.
module simd_int_lane
    import simd_lane_pkg::*;
#(
    parameter int VL_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    output logic                in_ready,
    input  logic [3:0]          in_op,
    input  logic [1:0]          in_sew,
    input  logic                in_red,
    input  logic                in_first,
    input  logic [VL_W-1:0]     in_vl,
    input  logic [WORD_W-1:0]   in_a,
    input  logic [WORD_W-1:0]   in_b,
    output logic                out_valid,
    input  logic                out_ready,
    output logic [WORD_W-1:0]   out_data,
    output logic                out_done
);
    lane_op_e           op_v;
    sew_e               sew_v;
    logic               accept;
    logic [3:0]         epw;
    logic [VL_W-1:0]    epw_ext;
    logic [VL_W-1:0]    elem_cnt;
    logic [VL_W-1:0]    elem_base;
    logic [VL_W-1:0]    remaining;
    logic               word_last;
    logic [3:0]         active;
    logic               red_busy;
    logic [WORD_W-1:0]  acc;
    logic [WORD_W-1:0]  base;
    logic [WORD_W-1:0]  vec_res;
    logic [WORD_W-1:0]  word_red;
    logic [WORD_W-1:0]  comb_res;
    logic [WORD_W-1:0]  sew_mask;

    assign op_v      = lane_op_e'(in_op);
    assign sew_v     = sew_e'(in_sew);
    assign in_ready  = !out_valid || out_ready;
    assign accept    = in_valid && in_ready;
    assign epw       = 4'd8 >> in_sew;
    assign epw_ext   = VL_W'(epw);
    assign elem_base = in_first ? '0 : elem_cnt;
    assign remaining = in_vl - elem_base;
    assign word_last = remaining <= epw_ext;
    assign active    = word_last ? remaining[3:0] : epw;
    assign base      = in_first ? in_b : acc;

    // Mask that keeps only element 0 of the reduction scalar.
    always_comb begin : p_mask
        case (sew_v)
            SEW_8:   sew_mask = 64'h0000_0000_0000_00FF;
            SEW_16:  sew_mask = 64'h0000_0000_0000_FFFF;
            SEW_32:  sew_mask = 64'h0000_0000_FFFF_FFFF;
            default: sew_mask = '1;
        endcase
    end

    simd_pack_op u_vec (
        .op  (op_v),
        .sew (sew_v),
        .a   (in_a),
        .b   (in_b),
        .y   (vec_res)
    );

    simd_word_reduce u_wred (
        .op     (op_v),
        .sew    (sew_v),
        .word   (in_a),
        .active (active),
        .red    (word_red)
    );

    simd_pack_op u_comb (
        .op  (op_v),
        .sew (sew_v),
        .a   (base),
        .b   (word_red),
        .y   (comb_res)
    );

    // Output register: load on a producing request, drain when consumed.
    always_ff @(posedge clk) begin : p_out_reg
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_done  <= 1'b0;
            out_data  <= '0;
        end else begin
            if (out_ready) begin
                out_valid <= 1'b0;
            end
            if (accept && (!in_red || word_last)) begin
                out_valid <= 1'b1;
                out_done  <= in_red;
                out_data  <= in_red ? (comb_res & sew_mask) : vec_res;
            end
        end
    end

    // Reduction state: accumulator and elements consumed so far.
    always_ff @(posedge clk) begin : p_red_state
        if (!rst_n) begin
            acc      <= '0;
            elem_cnt <= '0;
            red_busy <= 1'b0;
        end else if (accept && in_red) begin
            if (word_last) begin
                elem_cnt <= '0;
                red_busy <= 1'b0;
            end else begin
                acc      <= comb_res;
                elem_cnt <= elem_base + epw_ext;
                red_busy <= 1'b1;
            end
        end
    end

    // R8: an accepted elementwise request is visible right after the edge.
    assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept && !in_red |=> out_valid && !out_done);

    // R9: a stalled result holds its value.
    assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_done));

    // R11: a middle reduction word produces nothing.
    assert_mid_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_red && !word_last |=> !out_valid);

    // R6: the final reduction word produces a flagged scalar.
    assert_final_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        accept && in_red && word_last |=> out_valid && out_done);

    // R7: a continuing reduction has consumed fewer elements than the vector holds.
    assert_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        red_busy && accept && in_red && !in_first |-> elem_cnt < in_vl);
endmodule

// File: tb/simd_int_lane_tb.sv
// Bench: behavioural reference model (queues, integers) compared every clock.
module simd_int_lane_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [3:0]  in_op = '0;
    logic [1:0]  in_sew = '0;
    logic        in_red = 1'b0;
    logic        in_first = 1'b0;
    logic [15:0] in_vl = '0;
    logic [63:0] in_a = '0;
    logic [63:0] in_b = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [63:0] out_data;
    logic        out_done;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [3:0]  op;
        logic [1:0]  sew;
        logic        red;
        logic        first;
        logic [15:0] vl;
        logic [63:0] a;
        logic [63:0] b;
    } stim_t;

    stim_t       sq[$];
    logic [63:0] exp_data[$];
    logic        exp_done[$];
    string       exp_tag[$];

    always #4 clk = ~clk;

    simd_int_lane #(.VL_W(16)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_op(in_op), .in_sew(in_sew), .in_red(in_red), .in_first(in_first),
        .in_vl(in_vl), .in_a(in_a), .in_b(in_b), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .out_done(out_done)
    );

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    function automatic logic [63:0] m_mask(int ew);
        return (ew == 64) ? '1 : ((64'd1 << ew) - 64'd1);
    endfunction

    function automatic logic [63:0] m_sx(logic [63:0] v, int ew);
        return v[ew-1] ? (v | ~m_mask(ew)) : v;
    endfunction

    function automatic logic [63:0] m_elem(int op, int ew, logic [63:0] a, logic [63:0] b);
        logic [63:0] m = m_mask(ew);
        int sh = int'(b % 64'(ew));
        longint sa = longint'(m_sx(a, ew));
        longint sb = longint'(m_sx(b, ew));
        logic [63:0] r;
        case (op)
            0: r = a + b;
            1: r = a - b;
            2: r = a & b;
            3: r = a | b;
            4: r = a ^ b;
            5: r = a << sh;
            6: r = a >> sh;
            7: r = 64'(sa >>> sh);
            8: r = (sa < sb) ? a : b;
            9: r = (a < b) ? a : b;
            10: r = (sa > sb) ? a : b;
            11: r = (a > b) ? a : b;
            12: r = {63'd0, a == b};
            13: r = {63'd0, sa < sb};
            14: r = {63'd0, a < b};
            default: r = '0;
        endcase
        return r & m;
    endfunction

    function automatic logic [63:0] m_word(int op, int sew, logic [63:0] a, logic [63:0] b);
        int ew = 8 << sew;
        logic [63:0] m = m_mask(ew);
        logic [63:0] r = '0;
        for (int k = 0; k < 64 / ew; k++) begin
            r |= m_elem(op, ew, (a >> (k * ew)) & m, (b >> (k * ew)) & m) << (k * ew);
        end
        return r;
    endfunction

    function automatic string tag_of(int op);
        if (op <= 1) return "R1";
        if (op <= 4) return "R2";
        if (op <= 7) return "R3";
        if (op <= 11) return "R4";
        return "R5";
    endfunction

    task automatic add_vec(int op, int sew, logic [63:0] a, logic [63:0] b);
        stim_t s;
        s.op = 4'(op); s.sew = 2'(sew); s.red = 1'b0; s.first = 1'b0;
        s.vl = 16'd1; s.a = a; s.b = b;
        sq.push_back(s);
        exp_data.push_back(m_word(op, sew, a, b));
        exp_done.push_back(1'b0);
        exp_tag.push_back(tag_of(op));
    endtask

    task automatic add_red(int op, int sew, int vl);
        int ew = 8 << sew;
        int epw = 8 >> sew;
        int nw = (vl + epw - 1) / epw;
        logic [63:0] m = m_mask(ew);
        logic [63:0] words[$];
        logic [63:0] seed = {$urandom, $urandom};
        logic [63:0] acc = seed & m;
        for (int w = 0; w < nw; w++) words.push_back({$urandom, $urandom});
        for (int idx = 0; idx < vl; idx++) begin
            acc = m_elem(op, ew, acc, (words[idx / epw] >> ((idx % epw) * ew)) & m);
        end
        for (int w = 0; w < nw; w++) begin
            stim_t s;
            s.op = 4'(op); s.sew = 2'(sew); s.red = 1'b1; s.first = (w == 0);
            s.vl = 16'(vl); s.a = words[w];
            s.b = (w == 0) ? seed : {$urandom, $urandom};
            sq.push_back(s);
        end
        exp_data.push_back(acc);
        exp_done.push_back(1'b1);
        exp_tag.push_back((vl % epw != 0) ? "R7" : "R6");
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin : p_watchdog
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not complete, actual timeout expected completion");
        finish_run();
    end

    initial begin : p_main
        int rops[8] = '{0, 2, 3, 4, 8, 9, 10, 11};
        int si = 0;
        bit prev_stall = 1'b0;
        logic [63:0] prev_data = '0;
        logic prev_done = 1'b0;

        // Directed elementwise corners.
        add_vec(0, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0101_0101_0101_0101);  // R1 no carry across bytes
        add_vec(1, 1, 64'h0000_0000_0000_0000, 64'h0001_0001_0001_0001);  // R1 borrow stays in element
        add_vec(0, 2, 64'hFFFF_FFFF_0000_0001, 64'h0000_0001_FFFF_FFFF);  // R1
        add_vec(0, 3, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2);                    // R1
        add_vec(5, 0, 64'h0101_0101_0101_0101, 64'h0909_0909_0909_0909);  // R3 shift amount uses low bits
        add_vec(7, 1, 64'h8000_8000_7FFF_8001, 64'h0013_000F_0004_0001);  // R3 sign fill
        add_vec(6, 2, 64'h8000_0000_FFFF_FFFF, 64'h0000_0021_0000_001F);  // R3
        add_vec(8, 0, 64'h80FF_0180_7F00_0102, 64'h0101_FF01_8080_0201);  // R4 signed
        add_vec(9, 0, 64'h80FF_0180_7F00_0102, 64'h0101_FF01_8080_0201);  // R4 unsigned
        add_vec(13, 1, 64'h8000_0001_FFFF_1234, 64'h0001_8000_0000_1234); // R5
        add_vec(14, 1, 64'h8000_0001_FFFF_1234, 64'h0001_8000_0000_1234); // R5
        add_vec(12, 0, 64'h0011_2233_4455_6677, 64'h0011_2200_4455_0077); // R5
        for (int i = 0; i < 60; i++) begin
            add_vec(int'($urandom % 15), int'($urandom % 4), {$urandom, $urandom}, {$urandom, $urandom});
        end
        // Reductions: each op, each width, full, single, partial and random lengths (R6, R7).
        for (int oi = 0; oi < 8; oi++) begin
            for (int sw = 0; sw < 4; sw++) begin
                add_red(rops[oi], sw, 1);
                add_red(rops[oi], sw, 8 >> sw);
                add_red(rops[oi], sw, 2 * (8 >> sw) + 1);
                add_red(rops[oi], sw, 1 + int'($urandom % 20));
            end
        end

        // Reset state (R10).
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid in reset", 64'(out_valid), 64'd0);
        chk(out_done == 1'b0, "R10", "out_done in reset", 64'(out_done), 64'd0);
        chk(in_ready == 1'b1, "R9", "in_ready with empty output", 64'(in_ready), 64'd1);
        rst_n = 1'b1;

        // One-cycle latency (R8) and hold under stall (R9).
        @(negedge clk);
        in_valid = 1'b1; in_op = 4'd0; in_sew = 2'd0; in_red = 1'b0;
        in_a = 64'h0102_0304_0506_0708; in_b = 64'h1010_1010_1010_10FF;
        out_ready = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid == 1'b1, "R8", "out_valid after one edge", 64'(out_valid), 64'd1);
        chk(out_data == 64'h1112_1314_1516_1707, "R8", "data after one edge", out_data, 64'h1112_1314_1516_1707);
        chk(out_done == 1'b0, "R8", "out_done on elementwise", 64'(out_done), 64'd0);
        @(negedge clk);
        chk(out_valid && out_data == 64'h1112_1314_1516_1707, "R9", "held result", out_data, 64'h1112_1314_1516_1707);
        chk(in_ready == 1'b0, "R9", "in_ready while stalled", 64'(in_ready), 64'd0);
        rst_n = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R10", "out_valid after sync reset", 64'(out_valid), 64'd0);
        rst_n = 1'b1;

        // Main stream with random gaps and backpressure, compared every clock.
        while (si < sq.size() || exp_data.size() > 0) begin
            @(negedge clk);
            out_ready = ($urandom % 4) != 0;
            if (prev_stall) begin
                chk(out_valid == 1'b1, "R9", "valid held under stall", 64'(out_valid), 64'd1);
                chk(out_data == prev_data && out_done == prev_done, "R9", "data held under stall", out_data, prev_data);
            end
            if (si < sq.size() && ($urandom % 5) != 0) begin
                in_valid = 1'b1;
                in_op = sq[si].op; in_sew = sq[si].sew; in_red = sq[si].red;
                in_first = sq[si].first; in_vl = sq[si].vl; in_a = sq[si].a; in_b = sq[si].b;
            end else begin
                in_valid = 1'b0;
            end
            #1;
            if (out_valid && out_ready) begin
                if (exp_data.size() == 0) begin
                    chk(1'b0, "R11", "unexpected output", out_data, 64'd0);
                end else begin
                    chk(out_data == exp_data[0] && out_done == exp_done[0], exp_tag[0],
                        out_done ? "reduction scalar" : "elementwise word", out_data, exp_data[0]);
                    void'(exp_data.pop_front());
                    void'(exp_done.pop_front());
                    void'(exp_tag.pop_front());
                end
            end
            prev_stall = out_valid && !out_ready;
            prev_data = out_data;
            prev_done = out_done;
            if (in_valid && in_ready) si++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        out_ready = 1'b1;
        repeat (2) @(negedge clk);
        chk(out_valid == 1'b0, "R11", "no stray output after stream", 64'(out_valid), 64'd0);
        finish_run();
    end
endmodule